// File: doc/BRIEF.md
# Up/Down Wiper Counter Controller

This block keeps four 8-bit wiper position counters for a pair of dual-wiper digital potentiometers. An external host moves one counter at a time over a pin-level interface. The host pulls the active-low chip select low and picks a wiper with a two-bit select. It sets the direction input and then pulses a step clock. Each falling step-clock edge moves the chosen counter by one position. All of these pins are asynchronous to the system clock and are synchronized inside the block.

When the host releases chip select, the block looks at the step clock level at that moment. If the step clock is high, the write-protect pin allows writes, and the status register's level select is zero, the block raises a store request. The request carries the wiper index and the counter value, and the nonvolatile array outside the block saves it as that wiper's level-0 value. In every other case the session ends without a store. The external array reports activity on `nv_busy` and completes a request with `store_ack`. At reset each counter is recalled from the level-0 values that the array presents on `init_pos`.

Top module: `updn_wiper_ctrl`

## Requirements
- R1: One cycle after the internal reset is released, each counter i (bits [8i+7:8i] of `wiper_pos`) equals bits [8i+7:8i] of `init_pos`, and `store_req` is 0.
- R2: While chip select is low, a falling edge on `step_clk` with `dir_up` high increments the selected counter by one.
- R3: While chip select is low, a falling edge on `step_clk` with `dir_up` low decrements the selected counter by one.
- R4: The select input maps to counter indices as follows: 00 to index 0 (pot 0 wiper A), 11 to index 1 (pot 0 wiper B), 10 to index 2 (pot 1 wiper A), and 01 to index 3 (pot 1 wiper B). Only the selected counter moves.
- R5: A counter at FFh does not change on an up step, and a counter at 00h does not change on a down step.
- R6: While chip select is high, `step_clk` edges leave every counter unchanged.
- R7: A rising chip select while `step_clk` is high, `wprot_n` is high and `level_sel` is 00 raises `store_req`. At that point `store_idx` is the selected index and `store_data` is that counter's value.
- R8: A rising chip select while `step_clk` is low, or while `wprot_n` is low, raises no store request.
- R9: A rising chip select while `level_sel` is not 00 raises no store request.
- R10: `store_req`, `store_idx` and `store_data` hold until `store_ack` is sampled high, and `store_req` is low on the next cycle.
- R11: While `store_req` or `nv_busy` is high, step-clock edges leave every counter unchanged.
- R12: The direction input may change between steps within one chip-select session, and each step follows the direction present at its edge.
- R13: In any cycle after recall, at most one counter changes, and it changes by exactly one without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low select of the up/down interface (asynchronous) |
| step_clk | input | 1 | Step clock; a falling edge moves a counter (asynchronous) |
| dir_up | input | 1 | 1 = up, 0 = down (asynchronous) |
| wsel | input | 2 | Wiper select, non-binary mapping per R4 (asynchronous) |
| wprot_n | input | 1 | Active-low write protect; low blocks stores (asynchronous) |
| level_sel | input | 2 | Register level select from the status register; stores only at 00 |
| init_pos | input | 32 | Level-0 values recalled at reset, 8 bits per counter index |
| nv_busy | input | 1 | Nonvolatile array busy |
| store_ack | input | 1 | Array accepted the pending store |
| wiper_pos | output | 32 | Counter values, 8 bits per index |
| store_req | output | 1 | Store request pending |
| store_idx | output | 2 | Index of the counter to store |
| store_data | output | 8 | Value to store |

## Verification
The assertions check the rules that hold on every cycle. No counter wraps, no counter moves by more than one, and at most one counter changes per cycle. Counters stay frozen while chip select is high or a store is pending or busy. A store request always starts with the step clock high, writes permitted and level zero, and it holds steady until it is acknowledged. The bench scenarios are needed to show the rest: the recalled values, the select-to-wiper mapping, the direction followed at each step, saturation at both ends, and the exact index and value handed to the array.

// File: rtl/updn_pkg.sv
package updn_pkg;

  localparam int unsigned NUM_WIPERS = 4;
  localparam int unsigned IDX_W      = 2;

  typedef logic [IDX_W-1:0] wiper_idx_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } store_state_t;

  // Pin code to counter index: 00->0 (pot0 A), 11->1 (pot0 B), 10->2 (pot1 A), 01->3 (pot1 B)
  function automatic wiper_idx_t map_select(input logic [1:0] code);
    wiper_idx_t idx;
    case (code)
      2'b00:   idx = 2'd0;
      2'b11:   idx = 2'd1;
      2'b10:   idx = 2'd2;
      default: idx = 2'd3;
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/updn_rst_sync.sv
module updn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int unsigned           WIDTH   = 1,
  parameter int unsigned           STAGES  = 2,
  parameter logic [WIDTH-1:0]      RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= RST_VAL;
        end else begin
          stage_q[s] <= (s == 0) ? d : stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/updn_wiper_bank.sv
module updn_wiper_bank #(
  parameter int unsigned W  = 8,
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           recall,
  input  logic [N*W-1:0] init_flat,
  input  logic           step_en,
  input  logic [IW-1:0]  step_idx,
  input  logic           step_up,
  output logic [N*W-1:0] pos_flat
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cnt
      logic [W-1:0] cnt_q;
      logic [W-1:0] cnt_d;
      logic         hit;
      logic         at_top;
      logic         at_bot;
      logic         cnt_en;

      assign hit    = step_en && (step_idx == IW'(g));
      assign at_top = (cnt_q == {W{1'b1}});
      assign at_bot = (cnt_q == {W{1'b0}});

      // next state: recall has priority, then a saturating step
      always_comb begin
        cnt_d  = cnt_q;
        cnt_en = 1'b0;
        if (recall) begin
          cnt_d  = init_flat[g*W +: W];
          cnt_en = 1'b1;
        end else if (hit && step_up && !at_top) begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end else if (hit && !step_up && !at_bot) begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_d;
        end
      end

      assign pos_flat[g*W +: W] = cnt_q;
    end
  endgenerate

endmodule

// File: rtl/updn_store_ctl.sv
module updn_store_ctl
  import updn_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trigger,
  input  logic [IW-1:0] sel_idx,
  input  logic [W-1:0]  sel_data,
  input  logic          store_ack,
  output logic          store_req,
  output logic [IW-1:0] store_idx,
  output logic [W-1:0]  store_data
);

  store_state_t  state_q, state_d;
  logic          capture;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  data_q;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (trigger) begin
          state_d = ST_REQ;
          capture = 1'b1;
        end
      end
      ST_REQ: begin
        if (store_ack) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      data_q <= '0;
    end else if (capture) begin
      idx_q  <= sel_idx;
      data_q <= sel_data;
    end
  end

  assign store_req  = (state_q == ST_REQ);
  assign store_idx  = idx_q;
  assign store_data = data_q;

endmodule

// File: rtl/updn_wiper_ctrl.sv
module updn_wiper_ctrl
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        chip_sel_n,
  input  logic                        step_clk,
  input  logic                        dir_up,
  input  logic [1:0]                  wsel,
  input  logic                        wprot_n,
  input  logic [1:0]                  level_sel,
  input  logic [NUM_WIPERS*WIDTH-1:0] init_pos,
  input  logic                        nv_busy,
  input  logic                        store_ack,
  output logic [NUM_WIPERS*WIDTH-1:0] wiper_pos,
  output logic                        store_req,
  output logic [IDX_W-1:0]            store_idx,
  output logic [WIDTH-1:0]            store_data
);

  localparam int unsigned PIN_W   = 6;
  localparam logic [PIN_W-1:0] PIN_RST = 6'b100000;  // chip select idle high

  logic             core_rst_n;
  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             cs_n_s, step_s, dir_s, wp_s;
  logic [1:0]       wsel_s;
  logic             cs_prev_q, step_prev_q;
  logic             recall_pend;
  logic             step_fall, cs_rise;
  logic             busy, move_en, store_go;
  wiper_idx_t       sel_idx;
  logic [WIDTH-1:0] sel_data;

  updn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (core_rst_n)
  );

  assign pins_raw = {chip_sel_n, step_clk, dir_up, wsel, wprot_n};

  updn_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign {cs_n_s, step_s, dir_s, wsel_s, wp_s} = pins_s;

  // edge history and one-shot recall flag
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cs_prev_q   <= 1'b1;
      step_prev_q <= 1'b0;
      recall_pend <= 1'b1;
    end else begin
      cs_prev_q   <= cs_n_s;
      step_prev_q <= step_s;
      recall_pend <= 1'b0;
    end
  end

  always_comb begin
    step_fall = step_prev_q & ~step_s;
    cs_rise   = ~cs_prev_q & cs_n_s;
    busy      = store_req | nv_busy;
    sel_idx   = map_select(wsel_s);
    sel_data  = wiper_pos[sel_idx*WIDTH +: WIDTH];
    move_en   = step_fall & ~cs_n_s & ~busy & ~recall_pend;
    store_go  = cs_rise & step_s & wp_s & (level_sel == 2'b00) & ~busy & ~recall_pend;
  end

  updn_wiper_bank #(.W(WIDTH), .N(NUM_WIPERS), .IW(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .recall    (recall_pend),
    .init_flat (init_pos),
    .step_en   (move_en),
    .step_idx  (sel_idx),
    .step_up   (dir_s),
    .pos_flat  (wiper_pos)
  );

  updn_store_ctl #(.W(WIDTH), .IW(IDX_W)) u_store (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .trigger    (store_go),
    .sel_idx    (sel_idx),
    .sel_data   (sel_data),
    .store_ack  (store_ack),
    .store_req  (store_req),
    .store_idx  (store_idx),
    .store_data (store_data)
  );

endmodule

// File: rtl/updn_wiper_chk.sv
module updn_wiper_chk #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           recall_pend,
  input logic           cs_n_s,
  input logic           step_s,
  input logic           wp_s,
  input logic [1:0]     level_sel,
  input logic           nv_busy,
  input logic           store_ack,
  input logic           store_req,
  input logic [1:0]     store_idx,
  input logic [W-1:0]   store_data,
  input logic [N*W-1:0] wiper_pos
);

  logic [N*W-1:0] pos_prev;
  logic [N-1:0]   chg;

  always_ff @(posedge clk) pos_prev <= wiper_pos;

  always_comb begin
    for (int i = 0; i < N; i++) chg[i] = (wiper_pos[i*W +: W] != pos_prev[i*W +: W]);
  end

  assert_one_mover_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !recall_pend |=> ($countones(chg) <= 1));

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_step
      assert_unit_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !recall_pend |=> (wiper_pos[g*W +: W] == $past(wiper_pos[g*W +: W]) ||
                          {1'b0, wiper_pos[g*W +: W]} == {1'b0, $past(wiper_pos[g*W +: W])} + 1'b1 ||
                          {1'b0, wiper_pos[g*W +: W]} + 1'b1 == {1'b0, $past(wiper_pos[g*W +: W])}));
      assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall_pend && wiper_pos[g*W +: W] == {W{1'b1}}) |=> (wiper_pos[g*W +: W] != {W{1'b0}}));
    end
  endgenerate

  assert_frozen_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!recall_pend && cs_n_s) |=> $stable(wiper_pos));

  assert_frozen_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!recall_pend && (store_req || nv_busy)) |=> $stable(wiper_pos));

  assert_store_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_req) |-> (store_data == wiper_pos[store_idx*W +: W]));

  assert_store_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_req) |-> $past(step_s && wp_s));

  assert_store_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_req) |-> ($past(level_sel) == 2'b00));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req && !store_ack) |=> (store_req && $stable(store_idx) && $stable(store_data)));

  assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req && store_ack) |=> !store_req);

endmodule

bind updn_wiper_ctrl updn_wiper_chk #(.W(WIDTH), .N(updn_pkg::NUM_WIPERS)) u_chk (
  .clk         (clk),
  .rst_n       (core_rst_n),
  .recall_pend (recall_pend),
  .cs_n_s      (cs_n_s),
  .step_s      (step_s),
  .wp_s        (wp_s),
  .level_sel   (level_sel),
  .nv_busy     (nv_busy),
  .store_ack   (store_ack),
  .store_req   (store_req),
  .store_idx   (store_idx),
  .store_data  (store_data),
  .wiper_pos   (wiper_pos)
);

// File: tb/sim_updn_wiper_ctrl.sv
module sim_updn_wiper_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chip_sel_n, step_clk, dir_up, wprot_n, nv_busy, store_ack;
  logic [1:0]  wsel, level_sel;
  logic [31:0] init_pos;
  logic [31:0] wiper_pos;
  logic        store_req;
  logic [1:0]  store_idx;
  logic [7:0]  store_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model [4];

  always #5 clk = ~clk;

  updn_wiper_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .step_clk(step_clk),
    .dir_up(dir_up), .wsel(wsel), .wprot_n(wprot_n), .level_sel(level_sel),
    .init_pos(init_pos), .nv_busy(nv_busy), .store_ack(store_ack),
    .wiper_pos(wiper_pos), .store_req(store_req), .store_idx(store_idx),
    .store_data(store_data)
  );

  // {wsel, dir, expected value of the selected counter after the step}
  localparam logic [10:0] VEC [10] = '{
    {2'b00, 1'b1, 8'h11},   // R2 pot0 A up
    {2'b00, 1'b1, 8'h12},   // R2
    {2'b00, 1'b0, 8'h11},   // R3 R12 direction flips mid-session
    {2'b11, 1'b1, 8'hFF},   // R4 pot0 B up
    {2'b11, 1'b1, 8'hFF},   // R5 saturate high
    {2'b10, 1'b0, 8'h00},   // R4 pot1 A down
    {2'b10, 1'b0, 8'h00},   // R5 saturate low
    {2'b01, 1'b0, 8'h7F},   // R4 pot1 B down
    {2'b01, 1'b1, 8'h80},   // R12
    {2'b01, 1'b1, 8'h81}    // R2
  };

  function automatic int idx_of(input logic [1:0] s);
    case (s)
      2'b00:   return 0;
      2'b11:   return 1;
      2'b10:   return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [31:0] model_flat();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_pulse(input logic [1:0] s, input logic d);
    chip_sel_n = 1'b0;
    wsel       = s;
    dir_up     = d;
    wait_n(4);
    step_clk = 1'b1;
    wait_n(4);
    step_clk = 1'b0;
    wait_n(6);
  endtask

  task automatic end_session(input logic clk_level);
    step_clk = clk_level;
    wait_n(4);
    chip_sel_n = 1'b1;
    wait_n(6);
  endtask

  task automatic load_init();
    model[0] = 8'h10; model[1] = 8'hFE; model[2] = 8'h01; model[3] = 8'h80;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(6);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    chip_sel_n = 1'b1; step_clk = 1'b0; dir_up = 1'b0; wsel = 2'b00;
    wprot_n = 1'b1; level_sel = 2'b00; nv_busy = 1'b0; store_ack = 1'b0;
    init_pos = {8'h80, 8'h01, 8'hFE, 8'h10};
    load_init();
    @(negedge clk);
    do_reset();

    // R1: recall from level-0 values
    check("R1 recall", wiper_pos, model_flat());
    check("R1 no request", {31'b0, store_req}, 32'd0);

    // table walk: R2 R3 R4 R5 R12 R13
    for (int k = 0; k < 10; k++) begin
      logic [1:0] s;
      logic       d;
      logic [7:0] e;
      {s, d, e} = VEC[k];
      step_pulse(s, d);
      model[idx_of(s)] = e;
      check("R2 R3 R4 R5 R12 R13 step", wiper_pos, model_flat());
    end

    // R8: release with step clock low -> no store
    end_session(1'b0);
    check("R8 clk low no store", {31'b0, store_req}, 32'd0);

    // R6: edges while deselected
    for (int k = 0; k < 3; k++) begin
      step_clk = 1'b1; wait_n(4);
      step_clk = 1'b0; wait_n(4);
    end
    check("R6 deselected", wiper_pos, model_flat());

    // R7: store of pot1 B
    step_pulse(2'b01, 1'b1);
    model[3] = 8'h82;
    check("R2 pre-store", wiper_pos, model_flat());
    end_session(1'b1);
    check("R7 req", {31'b0, store_req}, 32'd1);
    check("R7 idx", {30'b0, store_idx}, 32'd3);
    check("R7 data", {24'b0, store_data}, 32'h82);
    wait_n(10);
    check("R10 held", {22'b0, store_req, store_idx, store_data}, {22'b0, 1'b1, 2'd3, 8'h82});

    // R11: steps ignored while request pending
    step_pulse(2'b00, 1'b1);
    check("R11 pending", wiper_pos, model_flat());
    end_session(1'b0);
    store_ack = 1'b1;
    wait_n(1);
    store_ack = 1'b0;
    wait_n(2);
    check("R10 released", {31'b0, store_req}, 32'd0);

    // R8: write protect low
    step_pulse(2'b00, 1'b1);
    model[0] = 8'h12;
    wprot_n = 1'b0;
    end_session(1'b1);
    check("R8 protected", {31'b0, store_req}, 32'd0);
    wprot_n = 1'b1;

    // R9: non-zero level select
    chip_sel_n = 1'b0;
    wait_n(4);
    level_sel = 2'b01;
    end_session(1'b1);
    check("R9 level", {31'b0, store_req}, 32'd0);
    level_sel = 2'b00;
    step_clk = 1'b0;
    wait_n(4);

    // R11: array busy
    nv_busy = 1'b1;
    step_pulse(2'b00, 1'b0);
    check("R11 busy", wiper_pos, model_flat());
    nv_busy = 1'b0;
    step_pulse(2'b00, 1'b0);
    model[0] = 8'h11;
    check("R3 after busy", wiper_pos, model_flat());
    end_session(1'b0);

    // R1: second reset restores recalled values
    do_reset();
    load_init();
    check("R1 re-recall", wiper_pos, model_flat());

    finish_run();
  end

endmodule